// File: doc/BRIEF.md
# Co-issue Admission Checker

This block decides, one candidate per cycle, whether a secondary instruction may be dispatched in the same slot as a primary instruction. The candidate's lane mask was captured at fetch and may be stale by the time it is considered. The block therefore first forms the dispatch mask as the lanes present both in that cached mask and in the live split mask. Every later decision uses that mask, and it is also driven out so that the scoreboard can run its hazard lookup on the lanes that will actually execute.

From the dispatch mask the block counts the lane-sets needed: the number of active lanes divided by the lane-set width, rounded up. It compares this count with the free lane-sets and combines the result with the scoreboard's answer. It then raises a grant or a one-hot denial reason. Each denial reason drives a saturating statistics counter. On a grant the block reports the lane-sets consumed and the free count that remains for the next candidate in the same slot.

Top module: `coiss_admit`

## Requirements
- R1: `effMask` equals the bitwise AND of `cachedMask` and `splitMask` in every cycle, combinationally.
- R2: With `candValid` high and `effMask` zero there is no grant, and `denyReason` is 3'b001 (bit 0: empty mask). `sbHazard` and `freeSets` have no effect in this case, and the hazard counter does not change.
- R3: With `candValid` high, `effMask` non-zero and `sbHazard` high, there is no grant and `denyReason` is 3'b010 (bit 1: scoreboard hazard). This reason takes precedence over a lane-set shortage.
- R4: The lane-sets needed equal ceil(popcount(`effMask`) / 2^s). Here s is `setShift`, clamped to 5, so set widths run from 1 to 32. `setsUsed` carries this value on a grant and is 0 otherwise.
- R5: When the sets needed exceed `freeSets` and no earlier reason applies, there is no grant and `denyReason` is 3'b100 (bit 2: no free sets). A need equal to `freeSets` is granted.
- R6: In every other case with `candValid` high, `grant` is 1 and `denyReason` is 0. `remainSets` equals `freeSets - setsUsed`, so it equals `freeSets` when there is no grant.
- R7: With `candValid` low, `grant` and `denyReason` are 0 and no counter changes.
- R8: Each denial increments the counter of its reason by one, and the new value is visible after the next rising clock edge. The counters are `cntEmpty`, `cntHazard` and `cntNoSets`, CNT_W bits wide (default 32). They saturate at all ones.
- R9: While `rstN` is low, all three counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| candValid | input | 1 | A candidate is presented this cycle |
| cachedMask | input | LANES | Lane mask captured at fetch |
| splitMask | input | LANES | Live lane mask of the split |
| freeSets | input | SET_W | Lane-sets still free in this slot |
| setShift | input | SHIFT_W | log2 of the lane-set width |
| sbHazard | input | 1 | Scoreboard hazard for `effMask` |
| effMask | output | LANES | Dispatch mask, to the scoreboard |
| grant | output | 1 | Candidate admitted |
| setsUsed | output | SET_W | Lane-sets consumed by the grant |
| remainSets | output | SET_W | Free lane-sets left after this candidate |
| denyReason | output | 3 | One-hot denial reason |
| cntEmpty | output | CNT_W | Empty-mask denials |
| cntHazard | output | CNT_W | Scoreboard denials |
| cntNoSets | output | CNT_W | Lane-set shortage denials |

## Verification
The block holds no state apart from the counters. An error in the mask, popcount or rounding path therefore shows in `effMask`, `setsUsed`, `grant` and `remainSets` in the same cycle as the candidate. Errors in priority or reason decoding show at once as a wrong one-hot `denyReason`. A faulty counter strobe or saturation rule shows on the counter ports one edge after the offending candidate, and the counter stays wrong from then on. The stimulus covers stale masks, an exact fit against an overflow by one set, both ends of the shift range including the clamp, and a counter driven past its maximum.

// File: rtl/coiss_pkg.sv
package coiss_pkg;
  localparam int RSN_EMPTY = 0;
  localparam int RSN_HAZARD = 1;
  localparam int RSN_NOSETS = 2;
  localparam int RSN_N = 3;

  typedef struct packed {
    logic grant;
    logic [RSN_N-1:0] inc;
  } admitStrobes_t;
endpackage

// File: rtl/coiss_datapath.sv
module coiss_datapath
  import coiss_pkg::*;
#(
  parameter int LANES = 32,
  parameter int CNT_W = 32,
  localparam int LOG_L = $clog2(LANES),
  localparam int SET_W = LOG_L + 1,
  localparam int SHIFT_W = $clog2(LOG_L + 1),
  localparam int POP_W = $clog2(LANES + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic [LANES-1:0] cachedMask,
  input  logic [LANES-1:0] splitMask,
  input  logic [SET_W-1:0] freeSets,
  input  logic [SHIFT_W-1:0] setShift,
  input  admitStrobes_t strb,
  output logic [LANES-1:0] effMask,
  output logic isEmpty,
  output logic overFree,
  output logic [SET_W-1:0] setsUsed,
  output logic [SET_W-1:0] remainSets,
  output logic [CNT_W-1:0] cntEmpty,
  output logic [CNT_W-1:0] cntHazard,
  output logic [CNT_W-1:0] cntNoSets
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [POP_W-1:0] popCnt;
  logic [SHIFT_W-1:0] shAmt;
  logic [POP_W:0] roundUp;
  logic [SET_W-1:0] needSets;
  logic [CNT_W-1:0] cnt [RSN_N];

  assign effMask = cachedMask & splitMask;
  assign isEmpty = (effMask == '0);

  always_comb begin
    popCnt = '0;
    for (int i = 0; i < LANES; i++) popCnt = popCnt + POP_W'(effMask[i]);
  end

  assign shAmt = (setShift > SHIFT_W'(LOG_L)) ? SHIFT_W'(LOG_L) : setShift;

  always_comb begin
    roundUp = {1'b0, popCnt} + (((POP_W+1)'(1)) << shAmt) - (POP_W+1)'(1);
    needSets = SET_W'(roundUp >> shAmt);
  end

  assign overFree = (needSets > freeSets);
  assign setsUsed = strb.grant ? needSets : '0;
  assign remainSets = freeSets - setsUsed;

  generate
    for (genvar g = 0; g < RSN_N; g++) begin : gCnt
      always_ff @(posedge clk) begin
        if (!rstN) cnt[g] <= '0;
        else if (strb.inc[g] && cnt[g] != CNT_MAX) cnt[g] <= cnt[g] + 1'b1;
      end

      a_r8_saturate : assert property (@(posedge clk) disable iff (!rstN)
        (cnt[g] == CNT_MAX) |=> (cnt[g] == CNT_MAX));
      a_r8_step : assert property (@(posedge clk) disable iff (!rstN)
        (strb.inc[g] && cnt[g] != CNT_MAX) |=> (cnt[g] == $past(cnt[g]) + 1'b1));
      a_r7_hold : assert property (@(posedge clk) disable iff (!rstN)
        !strb.inc[g] |=> $stable(cnt[g]));
    end
  endgenerate

  assign cntEmpty = cnt[RSN_EMPTY];
  assign cntHazard = cnt[RSN_HAZARD];
  assign cntNoSets = cnt[RSN_NOSETS];

  // R4: sets granted cover the active lanes and no set is wasted
  a_r4_ceiling : assert property (@(posedge clk) disable iff (!rstN)
    strb.grant |-> ((int'(setsUsed) << shAmt) >= int'(popCnt)) &&
                   (((int'(setsUsed) - 1) << shAmt) < int'(popCnt)));
  a_r5_fits : assert property (@(posedge clk) disable iff (!rstN)
    strb.grant |-> (setsUsed <= freeSets));
endmodule

// File: rtl/coiss_ctrl.sv
module coiss_ctrl
  import coiss_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic candValid,
  input  logic isEmpty,
  input  logic sbHazard,
  input  logic overFree,
  output admitStrobes_t strb,
  output logic [RSN_N-1:0] denyReason
);
  always_comb begin
    denyReason = '0;
    if (candValid) begin
      if (isEmpty) denyReason[RSN_EMPTY] = 1'b1;
      else if (sbHazard) denyReason[RSN_HAZARD] = 1'b1;
      else if (overFree) denyReason[RSN_NOSETS] = 1'b1;
    end
    strb.inc = denyReason;
    strb.grant = candValid && (denyReason == '0);
  end

  a_r6_onehot : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.grant, denyReason}));
  a_r7_idle : assert property (@(posedge clk) disable iff (!rstN)
    !candValid |-> (!strb.grant && denyReason == '0));
  a_r2_empty_first : assert property (@(posedge clk) disable iff (!rstN)
    (candValid && isEmpty) |-> denyReason[RSN_EMPTY]);
endmodule

// File: rtl/coiss_admit.sv
module coiss_admit
  import coiss_pkg::*;
#(
  parameter int LANES = 32,
  parameter int CNT_W = 32,
  localparam int LOG_L = $clog2(LANES),
  localparam int SET_W = LOG_L + 1,
  localparam int SHIFT_W = $clog2(LOG_L + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic candValid,
  input  logic [LANES-1:0] cachedMask,
  input  logic [LANES-1:0] splitMask,
  input  logic [SET_W-1:0] freeSets,
  input  logic [SHIFT_W-1:0] setShift,
  input  logic sbHazard,
  output logic [LANES-1:0] effMask,
  output logic grant,
  output logic [SET_W-1:0] setsUsed,
  output logic [SET_W-1:0] remainSets,
  output logic [2:0] denyReason,
  output logic [CNT_W-1:0] cntEmpty,
  output logic [CNT_W-1:0] cntHazard,
  output logic [CNT_W-1:0] cntNoSets
);
  admitStrobes_t strb;
  logic isEmpty;
  logic overFree;

  coiss_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .candValid(candValid), .isEmpty(isEmpty),
    .sbHazard(sbHazard), .overFree(overFree), .strb(strb),
    .denyReason(denyReason)
  );

  coiss_datapath #(.LANES(LANES), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .cachedMask(cachedMask), .splitMask(splitMask),
    .freeSets(freeSets), .setShift(setShift), .strb(strb), .effMask(effMask),
    .isEmpty(isEmpty), .overFree(overFree), .setsUsed(setsUsed),
    .remainSets(remainSets), .cntEmpty(cntEmpty), .cntHazard(cntHazard),
    .cntNoSets(cntNoSets)
  );

  assign grant = strb.grant;

  // R1: dispatch mask never holds a lane missing from either source mask
  a_r1_subset : assert property (@(posedge clk) disable iff (!rstN)
    ((effMask & ~cachedMask) == '0) && ((effMask & ~splitMask) == '0));
  a_r2_no_grant_empty : assert property (@(posedge clk) disable iff (!rstN)
    (effMask == '0) |-> !grant);
  a_r3_hazard_blocks : assert property (@(posedge clk) disable iff (!rstN)
    sbHazard |-> !grant);
  a_r6_remain : assert property (@(posedge clk) disable iff (!rstN)
    !grant |-> (remainSets == freeSets));
endmodule

// File: tb/tb_coiss_admit.sv
module tb_coiss_admit;
  localparam int LANES = 32;
  localparam int CNT_W = 4;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic candValid = 1'b0;
  logic [31:0] cachedMask = '0;
  logic [31:0] splitMask = '0;
  logic [5:0] freeSets = '0;
  logic [2:0] setShift = '0;
  logic sbHazard = 1'b0;
  logic [31:0] effMask;
  logic grant;
  logic [5:0] setsUsed;
  logic [5:0] remainSets;
  logic [2:0] denyReason;
  logic [CNT_W-1:0] cntEmpty, cntHazard, cntNoSets;

  int nChk = 0;
  int nBad = 0;
  int eCnt [3] = '{0, 0, 0};
  bit finished = 1'b0;

  always #2 clk = ~clk;

  coiss_admit #(.LANES(LANES), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .candValid(candValid), .cachedMask(cachedMask),
    .splitMask(splitMask), .freeSets(freeSets), .setShift(setShift),
    .sbHazard(sbHazard), .effMask(effMask), .grant(grant),
    .setsUsed(setsUsed), .remainSets(remainSets), .denyReason(denyReason),
    .cntEmpty(cntEmpty), .cntHazard(cntHazard), .cntNoSets(cntNoSets)
  );

  task automatic chk(string what, longint got, longint exp);
    nChk++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic chkCounters(string tag);
    chk({tag, " R8 cntEmpty"}, cntEmpty, eCnt[0]);
    chk({tag, " R8 cntHazard"}, cntHazard, eCnt[1]);
    chk({tag, " R8 cntNoSets"}, cntNoSets, eCnt[2]);
  endtask

  task automatic apply(string tag, bit v, logic [31:0] cm, logic [31:0] sm,
                       int free, int sh, bit hz);
    logic [31:0] m;
    int pop, w, need, rsn, used;
    bit g;
    @(negedge clk);
    candValid = v; cachedMask = cm; splitMask = sm;
    freeSets = 6'(free); setShift = 3'(sh); sbHazard = hz;
    m = cm & sm;
    pop = 0;
    for (int i = 0; i < 32; i++) if (m[i]) pop++;
    w = 1 << ((sh > 5) ? 5 : sh);
    need = (pop + w - 1) / w;
    rsn = 0; g = 0;
    if (v) begin
      if (pop == 0) rsn = 1;
      else if (hz) rsn = 2;
      else if (need > free) rsn = 4;
      else g = 1;
    end
    used = g ? need : 0;
    #1;
    chk({tag, " R1 effMask"}, effMask, m);
    chk({tag, " R6 grant"}, grant, g);
    chk({tag, " R2 R3 R5 R7 denyReason"}, denyReason, rsn);
    chk({tag, " R4 setsUsed"}, setsUsed, used);
    chk({tag, " R6 remainSets"}, remainSets, free - used);
    for (int k = 0; k < 3; k++)
      if (rsn[k] && eCnt[k] < CMAX) eCnt[k]++;
    @(posedge clk);
    #1;
    chkCounters(tag);
  endtask

  task automatic tReset();
    @(negedge clk);
    #1;
    chkCounters("reset R9");
    chk("reset R7 grant", grant, 0);
    chk("reset R7 denyReason", denyReason, 0);
  endtask

  task automatic tGrant();
    apply("grant", 1, 32'hFFFF_FFFF, 32'h0000_FFFF, 8, 2, 0);
    apply("stale", 1, 32'h0F0F_0F0F, 32'h00FF_00FF, 1, 3, 0);
  endtask

  task automatic tEmpty();
    apply("empty R2", 1, 32'h0000_00F0, 32'h0000_000F, 0, 0, 1);
  endtask

  task automatic tHazard();
    apply("hazard R3", 1, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0, 1);
    apply("hazardfit R3", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32, 5, 1);
  endtask

  task automatic tSets();
    apply("over R5", 1, 32'h0001_FFFF, 32'hFFFF_FFFF, 4, 2, 0);
    apply("exact R5", 1, 32'h0001_FFFF, 32'hFFFF_FFFF, 5, 2, 0);
  endtask

  task automatic tShift();
    apply("w1 R4", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32, 0, 0);
    apply("w1over R4", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 31, 0, 0);
    apply("w32 R4", 1, 32'h8000_0000, 32'hFFFF_FFFF, 1, 5, 0);
    apply("clamp R4", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 7, 0);
    apply("w8 R4", 1, 32'h0000_01FF, 32'hFFFF_FFFF, 2, 3, 0);
  endtask

  task automatic tIdle();
    apply("idle R7", 0, 32'h0000_00F0, 32'h0000_000F, 0, 0, 1);
    apply("idle2 R7", 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
  endtask

  task automatic tSaturate();
    for (int i = 0; i < 20; i++)
      apply("sat R8", 1, 32'h0, 32'hFFFF_FFFF, 4, 1, 0);
    chk("sat R8 cntEmpty max", cntEmpty, CMAX);
  endtask

  task automatic tResetAgain();
    @(negedge clk);
    rstN = 1'b0; candValid = 1'b0;
    @(posedge clk);
    #1;
    eCnt = '{0, 0, 0};
    chkCounters("rereset R9");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    tReset();
    @(negedge clk);
    rstN = 1'b1;
    tGrant();
    tEmpty();
    tHazard();
    tSets();
    tShift();
    tIdle();
    tSaturate();
    tResetAgain();
    tHazard();
    summary();
  end

  initial begin
    #400000;
    nChk++;
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule